// File: doc/BRIEF.md
# Tagged Bidirectional Byte FIFO for an Extended-Capability Parallel Port

This block is the byte store that sits between a host register port and the transfer engine of an extended-capability parallel port. It holds up to sixteen entries. Each entry is a data byte plus a one-bit tag that says whether the byte is a command (tag 1) or data (tag 0). A direction input picks which side fills the store. In forward direction (`cfg_dir` = 1) the host writes bytes and the engine drains them. In reverse direction (`cfg_dir` = 0) the engine fills the store and the host reads bytes out.

Host accesses are single-cycle strobes and are never stalled. A write to a full store is dropped. A read of an empty store is dropped. A host read always takes the entry at the head, whatever the direction. The engine side uses two valid/ready streams. `eng_in` accepts a byte when `eng_in_valid` and `eng_in_ready` are both high in the same cycle. `eng_out` hands over a byte when `eng_out_valid` and `eng_out_ready` are both high in the same cycle. Ready and valid depend only on state and configuration, never on the other side's strobe. A source may hold valid for as long as it likes. It must keep data and tag stable until the transfer is taken.

Mode codes 000 and 001 are the software-driven modes, which do not use the store. In those modes the block stays idle. Any change of direction or mode empties the store.

Top module: `ecp_tag_fifo`

## Requirements
- R1: While `rst_n` is low and after reset, the block shows `empty`=1, `full`=0, `level`=0, `host_rdata`=0 and `host_rtag`=0.
- R2: Entries leave in the order they were stored. Each byte leaves together with the tag it was stored with (tag 1 = command, tag 0 = data).
- R3: The store holds at most DEPTH (16) entries. When it is full, a host write or engine push is dropped and the stored contents do not change.
- R4: A host read while `empty` is high is dropped: `host_rdata` and `host_rtag` keep their previous values and `level` stays 0.
- R5: In forward direction (`cfg_dir`=1), a `host_wr` stores {`host_wtag`, `host_wdata`}. `eng_out_valid` is high whenever the store is not empty, and `eng_out_data`/`eng_out_tag` show the head entry. The head is removed on `eng_out_valid` && `eng_out_ready`. `eng_in_ready` stays low.
- R6: In reverse direction (`cfg_dir`=0), `eng_in_ready` equals not-full. An entry is stored on `eng_in_valid` && `eng_in_ready`. `host_wr` is dropped and `eng_out_valid` stays low.
- R7: In either direction, a `host_rd` on a non-empty store removes the head entry. Its byte and tag appear on `host_rdata`/`host_rtag` one clock later. If an engine pop happens in the same cycle, the engine pop wins and the host read is dropped.
- R8: When `cfg_mode` is 000 or 001, every access is dropped: `eng_in_ready`, `eng_out_valid` and `service` are low.
- R9: If `cfg_dir` or `cfg_mode` differs from the value seen at the previous clock, all accesses in that cycle are dropped. The store is emptied at the next edge, with all entries and tags cleared.
- R10: `service` is high in forward direction when `level` <= `cfg_thresh`, and in reverse direction when `level` >= `cfg_thresh`. It is low in the modes of R8 and in a cycle where the configuration changes.
- R11: `level` is the number of stored entries. `full` is high exactly when `level` = DEPTH, and `empty` is high exactly when `level` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir | input | 1 | Direction: 1 means the host fills the store, 0 means the engine fills it |
| cfg_mode | input | 3 | Port mode code; 000 and 001 leave the store idle |
| cfg_thresh | input | 5 | Level at which the service flag switches |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_wtag | input | 1 | Host write tag (1 = command) |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Byte returned by the last accepted host read |
| host_rtag | output | 1 | Tag returned by the last accepted host read |
| eng_in_valid | input | 1 | Engine push valid |
| eng_in_data | input | 8 | Engine push byte |
| eng_in_tag | input | 1 | Engine push tag |
| eng_in_ready | output | 1 | Store accepts an engine push |
| eng_out_valid | output | 1 | Head entry offered to the engine |
| eng_out_data | output | 8 | Head byte |
| eng_out_tag | output | 1 | Head tag |
| eng_out_ready | input | 1 | Engine takes the head entry |
| full | output | 1 | Store full |
| empty | output | 1 | Store empty |
| service | output | 1 | Threshold service flag |
| level | output | 5 | Number of stored entries |

## Verification
The bench targets the full and empty edges. It writes into a full store in the same cycle as a pop, and reads an empty store. A design that counted a pop before judging room would take an extra byte, and one that popped on empty would change `host_rdata`. It collides host reads with engine pops, where a wrong design would lose or duplicate a byte. It changes configuration with entries still held: a design without the flush would replay stale bytes, and one that let accesses through in that cycle would leave a stray entry. Tags alternate and are randomized throughout, so any mixing of tag and data order shows up at both read paths.

// File: rtl/ecp_fifo_pkg.sv
package ecp_fifo_pkg;
  localparam int unsigned ECP_DATA_W = 8;

  typedef struct packed {
    logic                  tag;
    logic [ECP_DATA_W-1:0] data;
  } ecp_entry_t;

  localparam int unsigned ECP_ENTRY_W = $bits(ecp_entry_t);
endpackage

// File: rtl/ecp_fifo_ctrl.sv
module ecp_fifo_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_dir,
  input  logic [2:0] cfg_mode,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       eng_in_valid,
  input  logic       eng_out_ready,
  input  logic       full,
  input  logic       empty,
  output logic       flush,
  output logic       active,
  output logic       eng_in_ready,
  output logic       eng_out_valid,
  output logic       push,
  output logic       push_sel_host,
  output logic       pop,
  output logic       host_pop
);
  logic       dir_q;
  logic [2:0] mode_q;
  logic       eng_pop;
  logic       fifo_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      mode_q <= 3'b000;
    end else begin
      dir_q  <= cfg_dir;
      mode_q <= cfg_mode;
    end
  end

  // Software-driven modes (000, 001) do not use the store.
  assign fifo_mode = (cfg_mode[2:1] != 2'b00);
  assign flush     = (cfg_dir != dir_q) || (cfg_mode != mode_q);
  assign active    = fifo_mode && !flush;

  assign eng_in_ready  = active && !cfg_dir && !full;
  assign eng_out_valid = active &&  cfg_dir && !empty;
  assign eng_pop       = eng_out_valid && eng_out_ready;
  assign host_pop      = active && host_rd && !empty && !eng_pop;
  assign pop           = eng_pop || host_pop;

  assign push_sel_host = cfg_dir;
  assign push          = cfg_dir ? (active && host_wr && !full)
                                 : (eng_in_valid && eng_in_ready);
endmodule

// File: rtl/ecp_fifo_store.sv
module ecp_fifo_store
  import ecp_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  ecp_entry_t       wentry,
  input  logic             pop,
  output ecp_entry_t       head,
  output logic [CNT_W-1:0] level
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  ecp_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (push) begin
      mem[wr_ptr] <= wentry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/ecp_fifo_level.sv
module ecp_fifo_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] thresh,
  input  logic             dir,
  input  logic             active,
  output logic             full,
  output logic             empty,
  output logic             service
);
  assign full  = (level == CNT_W'(DEPTH));
  assign empty = (level == '0);

  always_comb begin
    if (!active)  service = 1'b0;
    else if (dir) service = (level <= thresh);
    else          service = (level >= thresh);
  end
endmodule

// File: rtl/ecp_tag_fifo.sv
module ecp_tag_fifo
  import ecp_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned DW    = ECP_DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dir,
  input  logic [2:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_thresh,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_wtag,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  output logic             host_rtag,
  input  logic             eng_in_valid,
  input  logic [DW-1:0]    eng_in_data,
  input  logic             eng_in_tag,
  output logic             eng_in_ready,
  output logic             eng_out_valid,
  output logic [DW-1:0]    eng_out_data,
  output logic             eng_out_tag,
  input  logic             eng_out_ready,
  output logic             full,
  output logic             empty,
  output logic             service,
  output logic [CNT_W-1:0] level
);
  logic       flush, active, push, push_sel_host, pop, host_pop;
  ecp_entry_t wentry, head;

  ecp_fifo_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_dir       (cfg_dir),
    .cfg_mode      (cfg_mode),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .eng_in_valid  (eng_in_valid),
    .eng_out_ready (eng_out_ready),
    .full          (full),
    .empty         (empty),
    .flush         (flush),
    .active        (active),
    .eng_in_ready  (eng_in_ready),
    .eng_out_valid (eng_out_valid),
    .push          (push),
    .push_sel_host (push_sel_host),
    .pop           (pop),
    .host_pop      (host_pop)
  );

  assign wentry = push_sel_host ? ecp_entry_t'{tag: host_wtag,  data: host_wdata}
                                : ecp_entry_t'{tag: eng_in_tag, data: eng_in_data};

  ecp_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .push   (push),
    .wentry (wentry),
    .pop    (pop),
    .head   (head),
    .level  (level)
  );

  ecp_fifo_level #(.DEPTH(DEPTH)) u_level (
    .level   (level),
    .thresh  (cfg_thresh),
    .dir     (cfg_dir),
    .active  (active),
    .full    (full),
    .empty   (empty),
    .service (service)
  );

  // Host read result: byte and tag captured from the same head entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
      host_rtag  <= 1'b0;
    end else if (host_pop) begin
      host_rdata <= head.data;
      host_rtag  <= head.tag;
    end
  end

  assign eng_out_data = head.data;
  assign eng_out_tag  = head.tag;
endmodule

// File: rtl/ecp_tag_fifo_chk.sv
module ecp_tag_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_dir,
  input logic [2:0]       cfg_mode,
  input logic             host_wr,
  input logic             host_rd,
  input logic [7:0]       host_rdata,
  input logic             host_rtag,
  input logic             eng_in_valid,
  input logic             eng_in_ready,
  input logic             eng_out_valid,
  input logic             eng_out_ready,
  input logic             full,
  input logic             empty,
  input logic             service,
  input logic [CNT_W-1:0] level
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R11

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R3

  AST_FULL_NO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !eng_in_ready); // R6

  AST_FWD_NO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dir |-> !eng_in_ready); // R5

  AST_REV_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dir |-> !eng_out_valid); // R6

  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[2:1] == 2'b00) |-> (!eng_in_ready && !eng_out_valid && !service)); // R8

  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && host_rd) |=> ($stable(host_rdata) && $stable(host_rtag))); // R4

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_in_valid && eng_in_ready && !host_rd) |=> (level == $past(level) + CNT_W'(1))); // R6

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_out_valid && eng_out_ready && !host_wr) |=> (level == $past(level) - CNT_W'(1))); // R5

  AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_dir != $past(cfg_dir)) || (cfg_mode != $past(cfg_mode))) |=> empty); // R9
endmodule

bind ecp_tag_fifo ecp_tag_fifo_chk #(.DEPTH(DEPTH)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_dir       (cfg_dir),
  .cfg_mode      (cfg_mode),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .host_rdata    (host_rdata),
  .host_rtag     (host_rtag),
  .eng_in_valid  (eng_in_valid),
  .eng_in_ready  (eng_in_ready),
  .eng_out_valid (eng_out_valid),
  .eng_out_ready (eng_out_ready),
  .full          (full),
  .empty         (empty),
  .service       (service),
  .level         (level)
);

// File: tb/test_ecp_tag_fifo.sv
module test_ecp_tag_fifo;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_dir;
  logic [2:0]    cfg_mode;
  logic [CW-1:0] cfg_thresh;
  logic          host_wr, host_wtag, host_rd;
  logic [7:0]    host_wdata;
  logic [7:0]    host_rdata;
  logic          host_rtag;
  logic          eng_in_valid, eng_in_tag, eng_in_ready;
  logic [7:0]    eng_in_data;
  logic          eng_out_valid, eng_out_tag, eng_out_ready;
  logic [7:0]    eng_out_data;
  logic          full, empty, service;
  logic [CW-1:0] level;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [8:0] q[$];
  logic       m_dir;
  logic [2:0] m_mode;
  logic [8:0] m_rd;

  always #2 clk = ~clk;

  ecp_tag_fifo i_ecp_tag_fifo (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_service(input int n, input bit d, input int thr, input bit act);
    if (!act) return 1'b0;
    return d ? (n <= thr) : (n >= thr);
  endfunction

  task automatic idle_inputs();
    host_wr = 0; host_rd = 0; eng_in_valid = 0; eng_out_ready = 0;
  endtask

  // One clock with checks before and after the edge.
  task automatic step();
    bit changed, act, epop, hpop, hpush, epush;
    int n;
    logic [8:0] e;
    #1;
    n       = q.size();
    changed = (cfg_dir != m_dir) || (cfg_mode != m_mode);
    act     = !changed && (cfg_mode >= 3'd2);
    chk("R11 level", int'(level), n);
    chk("R11 full", int'(full), int'(n == DEPTH));
    chk("R11 empty", int'(empty), int'(n == 0));
    chk("R10 service", int'(service), int'(exp_service(n, cfg_dir, int'(cfg_thresh), act)));
    chk("R6 in_ready", int'(eng_in_ready), int'(act && !cfg_dir && n < DEPTH));
    chk("R5 out_valid", int'(eng_out_valid), int'(act && cfg_dir && n > 0));
    if (eng_out_valid && n > 0)
      chk("R2 head", int'({eng_out_tag, eng_out_data}), int'(q[0]));
    epop  = act && cfg_dir && n > 0 && eng_out_ready;
    hpop  = act && host_rd && n > 0 && !epop;
    hpush = act && cfg_dir && host_wr && n < DEPTH;
    epush = act && !cfg_dir && eng_in_valid && n < DEPTH;
    @(posedge clk);
    #1;
    if (changed) begin
      q.delete();
      m_dir  = cfg_dir;
      m_mode = cfg_mode;
    end else begin
      if (epop || hpop) begin
        e = q.pop_front();
        if (hpop) m_rd = e;
      end
      if (hpush) q.push_back({host_wtag, host_wdata});
      if (epush) q.push_back({eng_in_tag, eng_in_data});
    end
    chk("R7 host read", int'({host_rtag, host_rdata}), int'(m_rd));
  endtask

  task automatic set_cfg(input bit d, input logic [2:0] m);
    idle_inputs();
    cfg_dir = d; cfg_mode = m;
    step();
    chk("R9 flushed", int'(empty), 1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0EC9_5EED));
    rst_n = 0; cfg_dir = 1; cfg_mode = 3'd3; cfg_thresh = 5'd4;
    host_wdata = 0; host_wtag = 0; eng_in_data = 0; eng_in_tag = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 level", int'(level), 0);
    chk("R1 rdata", int'({host_rtag, host_rdata}), 0);
    rst_n = 1;
    m_dir = 0; m_mode = 0; m_rd = 0;
    step();  // configuration differs from reset value: flush cycle

    // Forward: overfill, then drain through the engine stream
    for (int i = 0; i < DEPTH + 2; i++) begin
      host_wr = 1; host_wdata = 8'(8'h30 + i); host_wtag = i[0];
      step();
    end
    idle_inputs();
    chk("R3 full held", int'(level), DEPTH);
    eng_out_ready = 1;
    for (int i = 0; i < DEPTH; i++) step();
    idle_inputs();
    host_rd = 1; step();
    chk("R4 empty read", int'(level), 0);

    // Host read vs engine pop collision, plus host read in forward mode
    idle_inputs();
    for (int i = 0; i < 4; i++) begin
      host_wr = 1; host_wdata = 8'(8'hA0 + i); host_wtag = ~i[0]; step();
    end
    host_wr = 0; host_rd = 1; eng_out_ready = 1; step();
    eng_out_ready = 0; step();
    idle_inputs();

    // Reverse with entries still held: flush, overfill through engine, host drains
    host_wr = 1; step();
    set_cfg(0, 3'd3);
    for (int i = 0; i < DEPTH + 2; i++) begin
      eng_in_valid = 1; eng_in_data = 8'(8'h50 + i); eng_in_tag = i[1];
      host_wr = 1;  // dropped in reverse direction
      step();
    end
    idle_inputs();
    host_rd = 1;
    for (int i = 0; i < DEPTH + 1; i++) step();
    idle_inputs();

    // Bypass mode: everything dropped
    eng_in_valid = 1; step(); step();
    idle_inputs();
    set_cfg(0, 3'd1);
    host_wr = 1; eng_in_valid = 1; host_rd = 1; eng_out_ready = 1;
    for (int i = 0; i < 4; i++) step();
    chk("R8 bypass level", int'(level), 0);
    chk("R8 bypass service", int'(service), 0);
    set_cfg(1, 3'd0);
    host_wr = 1;
    for (int i = 0; i < 3; i++) step();
    chk("R8 bypass forward", int'(eng_out_valid), 0);

    // Random traffic with occasional configuration changes
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 59) == 0) begin
        cfg_dir  = 1'($urandom_range(0, 1));
        cfg_mode = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(0, 1))
                                               : 3'($urandom_range(2, 7));
      end
      if ($urandom_range(0, 99) == 0) cfg_thresh = CW'($urandom_range(0, DEPTH));
      host_wr       = ($urandom_range(0, 2) != 0);
      host_wdata    = 8'($urandom);
      host_wtag     = 1'($urandom);
      host_rd       = ($urandom_range(0, 2) == 0);
      eng_in_valid  = ($urandom_range(0, 2) != 0);
      eng_in_data   = 8'($urandom);
      eng_in_tag    = 1'($urandom);
      eng_out_ready = ($urandom_range(0, 3) == 0);
      step();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule